// File: doc/BRIEF.md
# USB Host Interrupt Status Controller

This block keeps the event status word of a USB host controller and turns it into interrupt requests. The host controller core feeds it single-cycle event pulses and a few raw level conditions. Each event is caught in a sticky status bit. Software reads the word and clears bits by writing ones. An enable register, which carries a master enable in its top bit, gates the status into two lines. One is a normal interrupt line. The other is a separate management interrupt line, driven only by the ownership-change event.

Some bits come from derived conditions rather than from a plain pulse. The frame-number overflow bit sets when the frame counter's top bit toggles at a frame-number update. The resume bit sets on the rising edge of bus resume signalling, but not while the host itself is forcing resume. The done-head writeback bit also drops a writeback-allowed output, which holds the core off further writebacks until software clears the bit. Each scheduling overrun bumps a small wrapping counter.

The register port is a plain single-cycle port with no handshake. A write takes effect at the clock edge where it is presented. Read data is combinational from the selected register. There is no back-pressure anywhere in the block, and every event input is accepted in the cycle it is asserted.

Top module: `usbint_status_ctrl`

## Requirements
- R1: All registers reset to zero. The status bits are: 0 scheduling overrun, 1 done-head writeback, 2 start-of-frame, 3 resume detected, 4 unrecoverable error, 5 frame-number overflow, 6 root-hub change, 30 ownership change. Every other status bit reads 0. An event asserted in a cycle shows in the status word from the next cycle on.
- R2: Writing the status register (reg_sel=0) clears each bit written as 1. Bits written as 0 are untouched. A software write never sets a bit, and hardware never clears one.
- R3: At a cycle with frame_upd high, the frame-overflow bit (5) sets if frm_msb differs from the value it had at the previous frame_upd (zero after reset). Without frame_upd it does not set.
- R4: Bit 3 sets when resume_line rises from 0 to 1 while resume_force is 0. A line that stays high, or a rise while resume_force is 1, does not set it.
- R5: The enable register (reg_sel=1) stores bits 0-6, 30 and 31 and reads 0 elsewhere. Bit 31 is the master enable. irq is high when the master enable is set and any of status bits 0-6 is set together with its enable bit.
- R6: wb_allowed is the inverse of status bit 1. After a writeback pulse it stays low until software clears bit 1.
- R7: Each ovr_pulse increments the 2-bit ovr_count, which wraps modulo 4 and is not affected by clearing bit 0.
- R8: If a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set.
- R9: While sys_err is held high, bit 4 cannot be cleared. After sys_err falls, a clear works.
- R10: own_req sets bit 30, which drives mgmt_irq when enable bits 30 and 31 are both set and never drives irq. With HAS_MGMT_IRQ=0, bit 30 and mgmt_irq are tied to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_upd | input | 1 | Frame-number update strobe |
| frm_msb | input | 1 | Top bit of the frame number |
| sof_pulse | input | 1 | Start-of-frame event |
| wb_done | input | 1 | Done-head writeback completed |
| ovr_pulse | input | 1 | Scheduling overrun event |
| resume_line | input | 1 | Bus resume signalling seen (level) |
| resume_force | input | 1 | Host is forcing resume state (level) |
| rh_change | input | 1 | Root-hub status changed |
| sys_err | input | 1 | Non-USB system error (level) |
| own_req | input | 1 | Software ownership-change request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Normal interrupt |
| mgmt_irq | output | 1 | Management interrupt |
| wb_allowed | output | 1 | Core may perform a done-head writeback |
| ovr_count | output | 2 | Scheduling overrun counter |

## Verification
Several rules are checked on every cycle by the assertions. Each sticky bit holds unless a clear is written, and never sets without its event. Reserved bits stay zero. The master enable gates both interrupt lines. The counter steps exactly once per overrun. The frame and resume bits never set without their strobe or edge. The scenarios are needed to show that the derived conditions decode correctly: that a repeated frame MSB does not set overflow, and that a held or forced resume is ignored. They also show the register read-back masks, the set-over-clear priority, the unrecoverable-error hold, and the counter wrap after five overruns.

// File: rtl/usbint_pkg.sv
package usbint_pkg;
  localparam int REG_W = 32;

  localparam int B_OVR   = 0;
  localparam int B_WBDH  = 1;
  localparam int B_SOF   = 2;
  localparam int B_RSM   = 3;
  localparam int B_UERR  = 4;
  localparam int B_FOVF  = 5;
  localparam int B_RHCH  = 6;
  localparam int B_OWN   = 30;
  localparam int B_MEN   = 31;

  localparam logic SEL_STAT = 1'b0;
  localparam logic SEL_EN   = 1'b1;

  // Implemented status bits; bit 30 only with a management line.
  function automatic logic [REG_W-1:0] status_mask(input bit has_mgmt);
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = B_OVR; k <= B_RHCH; k++) m[k] = 1'b1;
    m[B_OWN] = has_mgmt;
    return m;
  endfunction

  // Bits of the status word that feed the normal interrupt line.
  function automatic logic [REG_W-1:0] normal_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = B_OVR; k <= B_RHCH; k++) m[k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/usbint_evt_cond.sv
module usbint_evt_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_upd,
  input  logic frm_msb,
  input  logic resume_line,
  input  logic resume_force,
  output logic fovf_set,
  output logic rsm_set
);
  logic msb_last_q;
  logic line_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_last_q  <= 1'b0;
      line_last_q <= 1'b0;
    end else begin
      if (frame_upd) msb_last_q <= frm_msb;
      line_last_q <= resume_line;
    end
  end

  assign fovf_set = frame_upd & (frm_msb ^ msb_last_q);
  assign rsm_set  = resume_line & ~line_last_q & ~resume_force;

  // The overflow condition only exists in a strobe cycle
  AST_FOVF_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    fovf_set |-> frame_upd); // R3
  // A line held high over two cycles never counts as a new resume
  AST_RSM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_line && $past(resume_line)) |-> !rsm_set); // R4
endmodule

// File: rtl/usbint_sticky_bank.sv
module usbint_sticky_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic b_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= 1'b0;
        else        b_q <= set_i[i] | (b_q & ~clr_i[i]);
      end
      assign q_o[i] = b_q;

      AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> q_o[i]); // R8
      AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o[i] && !clr_i[i]) |=> q_o[i]); // R2
      AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_o[i] && !set_i[i]) |=> !q_o[i]); // R2
    end else begin : g_rsvd
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usbint_ovr_counter.sv
module usbint_ovr_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + CNT_W'(1);
  end
  assign cnt = cnt_q;

  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt == $past(cnt) + CNT_W'(1))); // R7
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt)); // R7
endmodule

// File: rtl/usbint_status_ctrl.sv
module usbint_status_ctrl #(
  parameter int OVR_W        = 2,
  parameter bit HAS_MGMT_IRQ = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_upd,
  input  logic        frm_msb,
  input  logic        sof_pulse,
  input  logic        wb_done,
  input  logic        ovr_pulse,
  input  logic        resume_line,
  input  logic        resume_force,
  input  logic        rh_change,
  input  logic        sys_err,
  input  logic        own_req,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mgmt_irq,
  output logic        wb_allowed,
  output logic [OVR_W-1:0] ovr_count
);
  import usbint_pkg::*;

  localparam logic [REG_W-1:0] ST_IMPL = status_mask(HAS_MGMT_IRQ);
  localparam logic [REG_W-1:0] NRM_MSK = normal_mask();
  localparam logic [REG_W-1:0] EN_IMPL = ST_IMPL | (REG_W'(1) << B_MEN);

  logic             fovf_set, rsm_set;
  logic [REG_W-1:0] set_vec, clr_vec, status, en_q;

  usbint_evt_cond u_evt (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_upd    (frame_upd),
    .frm_msb      (frm_msb),
    .resume_line  (resume_line),
    .resume_force (resume_force),
    .fovf_set     (fovf_set),
    .rsm_set      (rsm_set)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_OVR]  = ovr_pulse;
    set_vec[B_WBDH] = wb_done;
    set_vec[B_SOF]  = sof_pulse;
    set_vec[B_RSM]  = rsm_set;
    set_vec[B_UERR] = sys_err;
    set_vec[B_FOVF] = fovf_set;
    set_vec[B_RHCH] = rh_change;
    set_vec[B_OWN]  = own_req & HAS_MGMT_IRQ;
  end

  assign clr_vec = (reg_wr && reg_sel == SEL_STAT) ? reg_wdata : '0;

  usbint_sticky_bank #(.W(REG_W), .IMPL(ST_IMPL)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .q_o   (status)
  );

  usbint_ovr_counter #(.CNT_W(OVR_W)) u_ovr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ovr_pulse),
    .cnt   (ovr_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          en_q <= '0;
    else if (reg_wr && reg_sel == SEL_EN) en_q <= reg_wdata & EN_IMPL;
  end

  assign reg_rdata  = (reg_sel == SEL_EN) ? en_q : status;
  assign irq        = en_q[B_MEN] & (|(status & en_q & NRM_MSK));
  assign mgmt_irq   = en_q[B_MEN] & en_q[B_OWN] & status[B_OWN];
  assign wb_allowed = ~status[B_WBDH];

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~ST_IMPL) == '0); // R1
  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[B_MEN] |-> (!irq && !mgmt_irq)); // R5
  AST_WB_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> !wb_allowed); // R6
  AST_FOVF_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[B_FOVF] && !frame_upd) |=> !status[B_FOVF]); // R3
  AST_RSM_NO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[B_RSM] && (resume_force || !resume_line)) |=> !status[B_RSM]); // R4
  AST_UERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |=> status[B_UERR]); // R9
  AST_OWN_NOT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq) |-> (|(status & NRM_MSK))); // R10

  if (HAS_MGMT_IRQ) begin : g_mgmt_chk
    AST_MGMT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (own_req && en_q[B_OWN] && en_q[B_MEN] && !(reg_wr && reg_sel == SEL_EN))
        |=> mgmt_irq); // R10
  end else begin : g_no_mgmt_chk
    AST_MGMT_TIED: assert property (@(posedge clk) disable iff (!rst_n)
      !mgmt_irq && !status[B_OWN]); // R10
  end
endmodule

// File: tb/usbint_status_ctrl_tb.sv
`timescale 1ns/100ps
module usbint_status_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_upd = 0, frm_msb = 0, sof_pulse = 0, wb_done = 0, ovr_pulse = 0;
  logic resume_line = 0, resume_force = 0, rh_change = 0, sys_err = 0, own_req = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, mgmt_irq, wb_allowed;
  logic [1:0] ovr_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic        irq;
    logic        mgmt;
    logic        wbok;
    logic [1:0]  ovr;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  usbint_status_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .frame_upd(frame_upd), .frm_msb(frm_msb),
    .sof_pulse(sof_pulse), .wb_done(wb_done), .ovr_pulse(ovr_pulse),
    .resume_line(resume_line), .resume_force(resume_force), .rh_change(rh_change),
    .sys_err(sys_err), .own_req(own_req), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mgmt_irq(mgmt_irq),
    .wb_allowed(wb_allowed), .ovr_count(ovr_count)
  );

  // Monitor: pops expected items and compares away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (reg_rdata !== e.rd || irq !== e.irq || mgmt_irq !== e.mgmt ||
            wb_allowed !== e.wbok || ovr_count !== e.ovr) begin
          errors++;
          $display("FAIL %s: got rd=%h irq=%b mgmt=%b wbok=%b ovr=%0d, expected rd=%h irq=%b mgmt=%b wbok=%b ovr=%0d",
                   e.tag, reg_rdata, irq, mgmt_irq, wb_allowed, ovr_count,
                   e.rd, e.irq, e.mgmt, e.wbok, e.ovr);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_now(string tag, logic [31:0] rd, logic i, logic m,
                            logic w, logic [1:0] o);
    exp_t e;
    e.tag = tag; e.rd = rd; e.irq = i; e.mgmt = m; e.wbok = w; e.ovr = o;
    exp_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic reg_write(logic sel, logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    expect_now("R1 reset state", 32'h0, 0, 0, 1, 0);

    sof_pulse = 1; tick(); sof_pulse = 0;
    expect_now("R1 sof sets bit2", 32'h4, 0, 0, 1, 0);
    rh_change = 1; tick(); rh_change = 0;
    expect_now("R1 root-hub sets bit6", 32'h44, 0, 0, 1, 0);

    reg_write(0, 32'h0);
    expect_now("R2 write zero no effect", 32'h44, 0, 0, 1, 0);
    reg_write(0, 32'h40);
    expect_now("R2 clear bit6 only", 32'h4, 0, 0, 1, 0);

    reg_write(1, 32'hFFFF_FFFF);
    reg_sel = 1;
    expect_now("R5 enable readback mask, irq on", 32'hC000_007F, 1, 0, 1, 0);
    reg_sel = 0;
    reg_write(1, 32'h0000_007F);
    reg_sel = 1;
    expect_now("R5 master off gates irq", 32'h0000_007F, 0, 0, 1, 0);
    reg_sel = 0;
    reg_write(1, 32'h8000_0004);
    expect_now("R5 bit2 enabled with master", 32'h4, 1, 0, 1, 0);
    reg_write(1, 32'h8000_0001);
    expect_now("R5 unmatched enable no irq", 32'h4, 0, 0, 1, 0);
    reg_write(0, 32'h4);
    expect_now("R2 clear sof", 32'h0, 0, 0, 1, 0);
    reg_write(0, 32'h7F);
    expect_now("R2 software cannot set", 32'h0, 0, 0, 1, 0);

    frm_msb = 0; frame_upd = 1; tick(); frame_upd = 0;
    expect_now("R3 msb unchanged no set", 32'h0, 0, 0, 1, 0);
    frm_msb = 1; tick();
    expect_now("R3 msb change without strobe", 32'h0, 0, 0, 1, 0);
    frame_upd = 1; tick(); frame_upd = 0;
    expect_now("R3 msb 0->1 sets bit5", 32'h20, 0, 0, 1, 0);
    reg_write(0, 32'h20);
    frame_upd = 1; tick(); frame_upd = 0;
    expect_now("R3 repeat msb 1 no set", 32'h0, 0, 0, 1, 0);
    frm_msb = 0; frame_upd = 1; tick(); frame_upd = 0;
    expect_now("R3 msb 1->0 sets bit5", 32'h20, 0, 0, 1, 0);
    reg_write(0, 32'h20);

    resume_line = 1; tick();
    expect_now("R4 resume rise sets bit3", 32'h8, 0, 0, 1, 0);
    reg_write(0, 32'h8);
    tick();
    expect_now("R4 held line no reset", 32'h0, 0, 0, 1, 0);
    resume_line = 0; tick();
    resume_force = 1; resume_line = 1; tick();
    expect_now("R4 forced resume ignored", 32'h0, 0, 0, 1, 0);
    resume_line = 0; resume_force = 0; tick();

    wb_done = 1; tick(); wb_done = 0;
    expect_now("R6 writeback held", 32'h2, 0, 0, 0, 0);
    tick();
    expect_now("R6 hold persists", 32'h2, 0, 0, 0, 0);
    reg_write(0, 32'h2);
    expect_now("R6 clear releases", 32'h0, 0, 0, 1, 0);

    ovr_pulse = 1; tick(); ovr_pulse = 0;
    expect_now("R7 overrun sets bit0 count 1", 32'h1, 1, 0, 1, 1);
    ovr_pulse = 1; repeat (4) tick(); ovr_pulse = 0;
    expect_now("R7 count wraps to 1", 32'h1, 1, 0, 1, 1);
    ovr_pulse = 1; tick(); ovr_pulse = 0;
    expect_now("R7 count 2", 32'h1, 1, 0, 1, 2);
    reg_write(0, 32'h1);
    expect_now("R7 clear keeps count", 32'h0, 0, 0, 1, 2);

    sof_pulse = 1; reg_sel = 0; reg_wdata = 32'h4; reg_wr = 1; tick();
    sof_pulse = 0; reg_wr = 0; reg_wdata = '0;
    expect_now("R8 set beats clear", 32'h4, 0, 0, 1, 2);
    reg_write(0, 32'h4);

    sys_err = 1; tick();
    expect_now("R9 error sets bit4", 32'h10, 0, 0, 1, 2);
    reg_write(0, 32'h10);
    expect_now("R9 clear blocked while error", 32'h10, 0, 0, 1, 2);
    sys_err = 0;
    reg_write(0, 32'h10);
    expect_now("R9 clear after error gone", 32'h0, 0, 0, 1, 2);

    reg_write(1, 32'hC000_0000);
    own_req = 1; tick(); own_req = 0;
    expect_now("R10 ownership mgmt irq", 32'h4000_0000, 0, 1, 1, 2);
    reg_write(1, 32'h4000_0000);
    expect_now("R10 master off gates mgmt", 32'h4000_0000, 0, 0, 1, 2);
    reg_write(1, 32'hC000_0000);
    reg_write(0, 32'h4000_0000);
    expect_now("R10 clear drops mgmt", 32'h0, 0, 0, 1, 2);

    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule